// File: doc/BRIEF.md
# Mode-Gated UART Host Register Bank

This block is the host-facing register bank of a 16550-style UART that carries an enhanced register set. A processor reaches it through a 3-bit address, an 8-bit write bus, an 8-bit read bus and separate read and write strobes. The value held in the line control register picks one of three access modes, and that mode, together with two enable bits, decides which physical register each address reaches. Writes land on the rising clock edge; reads are combinational from the current state.

The bank stores the interrupt enable, FIFO control, line control, modem control, enhanced feature, transmit-control trigger, trigger-level and scratch registers plus both divisor bytes. It presents them as decoded outputs to the baud generator, FIFOs and flow-control logic. The receive data, interrupt identification, line status and modem status values come in from outside and are only read back. A write to the transmit holding address raises a one-cycle push strobe with the data alongside.

Top module: `sio_cfg_regbank`

## Requirements
- R1: `acc_mode_o` reports the access mode from the line control value: 0 (operational) when bit 7 is 0, 2 (config B) when the value equals 0xBF exactly, 1 (config A) for any other value with bit 7 set.
- R2: Address 3 reads and writes the line control register in every mode; a write changes the mode from the next cycle.
- R3: In modes 1 and 2, address 0 is the low divisor byte and address 1 the high divisor byte; `divisor_o` is {high, low} and changes only through those writes.
- R4: In mode 0, address 0 reads `rx_data_i`, and a write there raises `thr_push_o` in the same cycle with `thr_data_o` equal to the write data; address 1 is the interrupt enable register.
- R5: Address 2 in mode 2 reads and writes the enhanced feature register; in modes 0 and 1 a write there loads the FIFO control register and a read returns `iir_stat_i`.
- R6: Address 4 is the modem control register in every mode; a write updates bits 7 and 6 only while enhanced feature bit 4 is 1, and bits 5..0 always.
- R7: An interrupt enable write updates bit 4 (sleep enable) only while enhanced feature bit 4 is 1; other bits always update.
- R8: While modem control bit 6 and enhanced feature bit 4 are both 1, addresses 6 and 7 reach the trigger control and trigger level registers; otherwise address 6 reads `msr_stat_i` (writes ignored) and address 7 is the scratch register.
- R9: Address 5 reads `lsr_stat_i` and writes to it change no register.
- R10: `rdata_o` is 0 whenever `rd_en_i` is low.
- R11: Reset clears every register, so the bank starts in mode 0 with a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rx_data_i | input | 8 | Receive data presented at address 0 |
| iir_stat_i | input | 8 | Interrupt identification value |
| lsr_stat_i | input | 8 | Line status value |
| msr_stat_i | input | 8 | Modem status value |
| thr_push_o | output | 1 | Transmit holding write strobe |
| thr_data_o | output | 8 | Transmit holding write data |
| acc_mode_o | output | 2 | Current access mode |
| divisor_o | output | 16 | Baud divisor |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| efr_o | output | 8 | Enhanced feature register |
| tcr_o | output | 8 | Trigger control register |
| tlr_o | output | 8 | Trigger level register |

## Verification
A read and a write can strike in one cycle, including on the same address and including a write to the line control register that moves the mode while a read decodes under the old one. The bench raises both strobes together on random addresses with line control values biased toward 0x00, 0x80, 0xBE, 0xBF and 0xFF. It judges the read against a model holding the state from before the edge, and the register outputs against the model updated after it, so a decode that used the incoming value would miscompare.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int AW = 3;
  localparam logic [7:0] LCR_KEY_B = 8'hBF;
  localparam int LCR_GATE_BIT = 7;
  localparam int EFR_ENH_BIT = 4;
  localparam int MCR_PAGE_BIT = 6;
  localparam logic [7:0] MCR_LOCK_MASK = 8'hC0;
  localparam logic [7:0] IER_LOCK_MASK = 8'h10;

  typedef enum logic [1:0] {
    MODE_OP = 2'd0,
    MODE_A  = 2'd1,
    MODE_B  = 2'd2
  } acc_mode_t;

  typedef enum logic [3:0] {
    SEL_RBR, SEL_IER, SEL_DLL, SEL_DLH, SEL_IIR, SEL_EFR, SEL_LCR,
    SEL_MCR, SEL_LSR, SEL_MSR, SEL_TCR, SEL_TLR, SEL_SPR
  } rsel_t;

  typedef struct packed {
    logic thr;
    logic ier;
    logic dll;
    logic dlh;
    logic fcr;
    logic efr;
    logic lcr;
    logic mcr;
    logic tcr;
    logic tlr;
    logic spr;
  } wsel_t;
endpackage

// File: rtl/sio_mode_dec.sv
module sio_mode_dec
  import sio_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lcr_i,
  output acc_mode_t     mode_o
);
  always_comb begin
    if (!lcr_i[LCR_GATE_BIT])            mode_o = MODE_OP;
    else if (lcr_i == DW'(LCR_KEY_B))    mode_o = MODE_B;
    else                                 mode_o = MODE_A;
  end
endmodule

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
  import sio_cfg_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  acc_mode_t     mode_i,
  input  logic          page_open_i,
  output rsel_t         rsel_o,
  output wsel_t         wsel_o
);
  always_comb begin
    case (addr_i)
      3'd0:    rsel_o = (mode_i == MODE_OP) ? SEL_RBR : SEL_DLL;
      3'd1:    rsel_o = (mode_i == MODE_OP) ? SEL_IER : SEL_DLH;
      3'd2:    rsel_o = (mode_i == MODE_B)  ? SEL_EFR : SEL_IIR;
      3'd3:    rsel_o = SEL_LCR;
      3'd4:    rsel_o = SEL_MCR;
      3'd5:    rsel_o = SEL_LSR;
      3'd6:    rsel_o = page_open_i ? SEL_TCR : SEL_MSR;
      default: rsel_o = page_open_i ? SEL_TLR : SEL_SPR;
    endcase
  end

  always_comb begin
    wsel_o = '0;
    if (wr_en_i) begin
      case (rsel_o)
        SEL_RBR: wsel_o.thr = 1'b1;
        SEL_IER: wsel_o.ier = 1'b1;
        SEL_DLL: wsel_o.dll = 1'b1;
        SEL_DLH: wsel_o.dlh = 1'b1;
        SEL_IIR: wsel_o.fcr = 1'b1;
        SEL_EFR: wsel_o.efr = 1'b1;
        SEL_LCR: wsel_o.lcr = 1'b1;
        SEL_MCR: wsel_o.mcr = 1'b1;
        SEL_TCR: wsel_o.tcr = 1'b1;
        SEL_TLR: wsel_o.tlr = 1'b1;
        SEL_SPR: wsel_o.spr = 1'b1;
        default: wsel_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rd_en_i,
  input  rsel_t         rsel_i,
  input  logic [DW-1:0] rbr_i,
  input  logic [DW-1:0] ier_i,
  input  logic [DW-1:0] dll_i,
  input  logic [DW-1:0] dlh_i,
  input  logic [DW-1:0] iir_i,
  input  logic [DW-1:0] efr_i,
  input  logic [DW-1:0] lcr_i,
  input  logic [DW-1:0] mcr_i,
  input  logic [DW-1:0] lsr_i,
  input  logic [DW-1:0] msr_i,
  input  logic [DW-1:0] tcr_i,
  input  logic [DW-1:0] tlr_i,
  input  logic [DW-1:0] spr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] pick;

  always_comb begin
    case (rsel_i)
      SEL_RBR: pick = rbr_i;
      SEL_IER: pick = ier_i;
      SEL_DLL: pick = dll_i;
      SEL_DLH: pick = dlh_i;
      SEL_IIR: pick = iir_i;
      SEL_EFR: pick = efr_i;
      SEL_LCR: pick = lcr_i;
      SEL_MCR: pick = mcr_i;
      SEL_LSR: pick = lsr_i;
      SEL_MSR: pick = msr_i;
      SEL_TCR: pick = tcr_i;
      SEL_TLR: pick = tlr_i;
      default: pick = spr_i;
    endcase
    rdata_o = rd_en_i ? pick : '0;
  end
endmodule

// File: rtl/sio_cfg_regbank.sv
module sio_cfg_regbank
  import sio_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [DW-1:0]   rx_data_i,
  input  logic [DW-1:0]   iir_stat_i,
  input  logic [DW-1:0]   lsr_stat_i,
  input  logic [DW-1:0]   msr_stat_i,
  output logic            thr_push_o,
  output logic [DW-1:0]   thr_data_o,
  output logic [1:0]      acc_mode_o,
  output logic [2*DW-1:0] divisor_o,
  output logic [DW-1:0]   ier_o,
  output logic [DW-1:0]   fcr_o,
  output logic [DW-1:0]   lcr_o,
  output logic [DW-1:0]   mcr_o,
  output logic [DW-1:0]   efr_o,
  output logic [DW-1:0]   tcr_o,
  output logic [DW-1:0]   tlr_o
);
  localparam logic [DW-1:0] MCR_LOCK = DW'(MCR_LOCK_MASK);
  localparam logic [DW-1:0] IER_LOCK = DW'(IER_LOCK_MASK);

  logic [DW-1:0] ier_q, fcr_q, lcr_q, mcr_q, efr_q, tcr_q, tlr_q, spr_q, dll_q, dlh_q;
  logic [DW-1:0] ier_d, fcr_d, lcr_d, mcr_d, efr_d, tcr_d, tlr_d, spr_d, dll_d, dlh_d;
  acc_mode_t     mode;
  rsel_t         rsel;
  wsel_t         wsel;
  logic          enh_on;
  logic          page_open;

  assign enh_on    = efr_q[EFR_ENH_BIT];
  assign page_open = enh_on & mcr_q[MCR_PAGE_BIT];

  sio_mode_dec #(.DW(DW)) u_mode (
    .lcr_i  (lcr_q),
    .mode_o (mode)
  );

  sio_addr_dec u_adec (
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .mode_i      (mode),
    .page_open_i (page_open),
    .rsel_o      (rsel),
    .wsel_o      (wsel)
  );

  sio_rd_mux #(.DW(DW)) u_rmux (
    .rd_en_i (rd_en_i),
    .rsel_i  (rsel),
    .rbr_i   (rx_data_i),
    .ier_i   (ier_q),
    .dll_i   (dll_q),
    .dlh_i   (dlh_q),
    .iir_i   (iir_stat_i),
    .efr_i   (efr_q),
    .lcr_i   (lcr_q),
    .mcr_i   (mcr_q),
    .lsr_i   (lsr_stat_i),
    .msr_i   (msr_stat_i),
    .tcr_i   (tcr_q),
    .tlr_i   (tlr_q),
    .spr_i   (spr_q),
    .rdata_o (rdata_o)
  );

  // next-state
  always_comb begin
    ier_d = ier_q;
    fcr_d = fcr_q;
    lcr_d = lcr_q;
    mcr_d = mcr_q;
    efr_d = efr_q;
    tcr_d = tcr_q;
    tlr_d = tlr_q;
    spr_d = spr_q;
    dll_d = dll_q;
    dlh_d = dlh_q;
    if (wsel.ier) ier_d = enh_on ? wdata_i : ((wdata_i & ~IER_LOCK) | (ier_q & IER_LOCK));
    if (wsel.mcr) mcr_d = enh_on ? wdata_i : ((wdata_i & ~MCR_LOCK) | (mcr_q & MCR_LOCK));
    if (wsel.fcr) fcr_d = wdata_i;
    if (wsel.lcr) lcr_d = wdata_i;
    if (wsel.efr) efr_d = wdata_i;
    if (wsel.tcr) tcr_d = wdata_i;
    if (wsel.tlr) tlr_d = wdata_i;
    if (wsel.spr) spr_d = wdata_i;
    if (wsel.dll) dll_d = wdata_i;
    if (wsel.dlh) dlh_d = wdata_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      fcr_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      efr_q <= '0;
      tcr_q <= '0;
      tlr_q <= '0;
      spr_q <= '0;
      dll_q <= '0;
      dlh_q <= '0;
    end else begin
      ier_q <= ier_d;
      fcr_q <= fcr_d;
      lcr_q <= lcr_d;
      mcr_q <= mcr_d;
      efr_q <= efr_d;
      tcr_q <= tcr_d;
      tlr_q <= tlr_d;
      spr_q <= spr_d;
      dll_q <= dll_d;
      dlh_q <= dlh_d;
    end
  end

  assign thr_push_o = wsel.thr;
  assign thr_data_o = wdata_i;
  assign acc_mode_o = mode;
  assign divisor_o  = {dlh_q, dll_q};
  assign ier_o      = ier_q;
  assign fcr_o      = fcr_q;
  assign lcr_o      = lcr_q;
  assign mcr_o      = mcr_q;
  assign efr_o      = efr_q;
  assign tcr_o      = tcr_q;
  assign tlr_o      = tlr_q;
endmodule

// File: rtl/sio_cfg_regbank_chk.sv
module sio_cfg_regbank_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      addr_i,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic            thr_push_o,
  input logic [1:0]      acc_mode_o,
  input logic [2*DW-1:0] divisor_o,
  input logic [DW-1:0]   ier_o,
  input logic [DW-1:0]   lcr_o,
  input logic [DW-1:0]   mcr_o,
  input logic [DW-1:0]   efr_o
);
  AST_LCR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd3) |=> (lcr_o == $past(wdata_i))); // R2

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && acc_mode_o != 2'd0 && addr_i <= 3'd1) |=> $stable(divisor_o)); // R3

  AST_THR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_push_o |-> (acc_mode_o == 2'd0 && addr_i == 3'd0 && wr_en_i)); // R4

  AST_EFR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && acc_mode_o == 2'd2 && addr_i == 3'd2) |=> $stable(efr_o)); // R5

  AST_MCR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd4 && !efr_o[4]) |=> (mcr_o[7:6] == $past(mcr_o[7:6]))); // R6

  AST_IER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd1 && acc_mode_o == 2'd0 && !efr_o[4]) |=> (ier_o[4] == $past(ier_o[4]))); // R7

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (rdata_o == '0)); // R10
endmodule

bind sio_cfg_regbank sio_cfg_regbank_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .thr_push_o (thr_push_o),
  .acc_mode_o (acc_mode_o),
  .divisor_o  (divisor_o),
  .ier_o      (ier_o),
  .lcr_o      (lcr_o),
  .mcr_o      (mcr_o),
  .efr_o      (efr_o)
);

// File: tb/sio_cfg_regbank_tb.sv
`timescale 1ns/1ps
module sio_cfg_regbank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata, rx_data, iir_stat, lsr_stat, msr_stat;
  logic       thr_push;
  logic [7:0] thr_data;
  logic [1:0] acc_mode;
  logic [15:0] divisor;
  logic [7:0] ier, fcr, lcr, mcr, efr, tcr, tlr;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [7:0] m_ier, m_fcr, m_lcr, m_mcr, m_efr, m_tcr, m_tlr, m_spr, m_dll, m_dlh;

  always #2.5 clk = ~clk;

  sio_cfg_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .iir_stat_i(iir_stat),
    .lsr_stat_i(lsr_stat), .msr_stat_i(msr_stat), .thr_push_o(thr_push),
    .thr_data_o(thr_data), .acc_mode_o(acc_mode), .divisor_o(divisor),
    .ier_o(ier), .fcr_o(fcr), .lcr_o(lcr), .mcr_o(mcr), .efr_o(efr),
    .tcr_o(tcr), .tlr_o(tlr)
  );

  function automatic logic [1:0] mode_of(input logic [7:0] l);
    if (!l[7]) return 2'd0;
    if (l == 8'hBF) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic page_of();
    return m_mcr[6] & m_efr[4];
  endfunction

  function automatic logic [7:0] model_read(input logic [2:0] a);
    logic [1:0] md;
    md = mode_of(m_lcr);
    case (a)
      3'd0: return (md == 2'd0) ? rx_data : m_dll;
      3'd1: return (md == 2'd0) ? m_ier : m_dlh;
      3'd2: return (md == 2'd2) ? m_efr : iir_stat;
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return lsr_stat;
      3'd6: return page_of() ? m_tcr : msr_stat;
      default: return page_of() ? m_tlr : m_spr;
    endcase
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    logic [1:0] md;
    logic enh, pg;
    md = mode_of(m_lcr);
    enh = m_efr[4];
    pg = page_of();
    case (a)
      3'd0: if (md != 2'd0) m_dll = d;
      3'd1: if (md != 2'd0) m_dlh = d;
            else m_ier = enh ? d : {d[7:5], m_ier[4], d[3:0]};
      3'd2: if (md == 2'd2) m_efr = d; else m_fcr = d;
      3'd3: m_lcr = d;
      3'd4: m_mcr = enh ? d : {m_mcr[7:6], d[5:0]};
      3'd5: ;
      3'd6: if (pg) m_tcr = d;
      default: if (pg) m_tlr = d; else m_spr = d;
    endcase
  endtask

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk(lcr == m_lcr, "R2 lcr", {8'h0, lcr}, {8'h0, m_lcr});
    chk(divisor == {m_dlh, m_dll}, "R3 divisor", divisor, {m_dlh, m_dll});
    chk(ier == m_ier, "R7 ier", {8'h0, ier}, {8'h0, m_ier});
    chk(mcr == m_mcr, "R6 mcr", {8'h0, mcr}, {8'h0, m_mcr});
    chk(efr == m_efr, "R5 efr", {8'h0, efr}, {8'h0, m_efr});
    chk(fcr == m_fcr, "R5 fcr", {8'h0, fcr}, {8'h0, m_fcr});
    chk(tcr == m_tcr, "R8 tcr", {8'h0, tcr}, {8'h0, m_tcr});
    chk(tlr == m_tlr, "R8 tlr", {8'h0, tlr}, {8'h0, m_tlr});
  endtask

  // one bus cycle, called at a falling edge
  task automatic op(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    logic [7:0] exp_rd;
    logic exp_push;
    addr = a; wr_en = w; rd_en = r; wdata = d;
    rx_data = 8'($urandom); iir_stat = 8'($urandom);
    lsr_stat = 8'($urandom); msr_stat = 8'($urandom);
    #1;
    chk(acc_mode == mode_of(m_lcr), "R1 mode", {14'h0, acc_mode}, {14'h0, mode_of(m_lcr)});
    exp_rd = r ? model_read(a) : 8'h00;
    chk(rdata == exp_rd, r ? "R8 read (R4/R5/R9)" : "R10 idle read", {8'h0, rdata}, {8'h0, exp_rd});
    exp_push = w && mode_of(m_lcr) == 2'd0 && a == 3'd0;
    chk(thr_push == exp_push, "R4 push", {15'h0, thr_push}, {15'h0, exp_push});
    if (exp_push) chk(thr_data == d, "R4 data", {8'h0, thr_data}, {8'h0, d});
    @(posedge clk);
    if (w) model_write(a, d);
    @(negedge clk);
    check_regs();
  endtask

  function automatic logic [7:0] pick_lcr();
    case ($urandom % 7)
      0: return 8'h00;
      1: return 8'h03;
      2: return 8'h80;
      3: return 8'hBF;
      4: return 8'hBE;
      5: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
    rx_data = '0; iir_stat = '0; lsr_stat = '0; msr_stat = '0;
    {m_ier, m_fcr, m_lcr, m_mcr, m_efr, m_tcr, m_tlr, m_spr, m_dll, m_dlh} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(acc_mode == 2'd0, "R11 mode", {14'h0, acc_mode}, 16'h0);
    chk(lcr == 0 && efr == 0 && mcr == 0 && ier == 0, "R11 regs", {lcr, efr}, 16'h0);
    chk(divisor == 16'h0, "R11 divisor", divisor, 16'h0);
    @(negedge clk);

    // directed: mode A divisor, R3
    op(1, 0, 3'd3, 8'h80);
    op(1, 0, 3'd0, 8'h34);
    op(1, 1, 3'd1, 8'h12);
    op(0, 1, 3'd0, 8'h00);
    op(0, 1, 3'd2, 8'h00);           // R5 iir in mode A
    // mode B: divisor still reachable, EFR open
    op(1, 0, 3'd3, 8'hBF);
    op(0, 1, 3'd1, 8'h00);           // R3 in mode B
    op(1, 1, 3'd2, 8'h00);
    // MCR locked without enhanced enable, R6
    op(1, 0, 3'd4, 8'hFF);
    op(1, 0, 3'd3, 8'h03);
    op(1, 0, 3'd1, 8'hFF);           // R7 sleep bit held
    op(1, 1, 3'd0, 8'hA5);           // R4 push
    op(1, 1, 3'd5, 8'h77);           // R9
    op(1, 1, 3'd6, 8'h66);           // R8 msr path, write ignored
    op(1, 1, 3'd7, 8'h99);           // R8 scratch
    // enable enhanced, open page
    op(1, 0, 3'd3, 8'hBF);
    op(1, 0, 3'd2, 8'h10);
    op(1, 0, 3'd3, 8'hBE);           // R1 near-key is mode A
    op(1, 0, 3'd4, 8'hC5);           // R6 unlocked
    op(1, 1, 3'd6, 8'h3C);           // R8 tcr
    op(1, 1, 3'd7, 8'h4D);           // R8 tlr
    op(0, 1, 3'd6, 8'h00);
    op(1, 0, 3'd3, 8'h00);
    op(1, 1, 3'd1, 8'hFF);           // R7 sleep bit writable
    op(1, 1, 3'd3, 8'hBF);           // same-cycle read of old LCR

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom);
      d = (a == 3'd3) ? pick_lcr() :
          (a == 3'd2 && ($urandom % 2) == 0) ? (8'($urandom) | 8'h10) : 8'($urandom);
      op(1'($urandom), 1'($urandom), a, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule